// File: doc/BRIEF.md
# Variable-length instruction parcel assembler

This block turns a stream of 16-bit instruction parcels, arriving in increasing halfword address order, into whole instructions. Each parcel enters through a valid/ready handshake. The block reads only the low bits of the first parcel of an instruction, works out how many parcels the instruction spans, and gathers them. It then presents the finished instruction on a valid/ready output. The word is right-aligned and zero-padded up to the maximum supported length. The output also carries the parcel count and a classification code.

Two parameters fix the variant. `ILEN` is the longest instruction accepted, in bits, and must be a multiple of 16 and at least 32. `COMPRESSED` says whether one-parcel instructions exist. A synchronous flush discards a partly gathered instruction so that a fetch unit can restart the stream after a redirect.

Top module: `parcel_assembler`

## Requirements
- R1: With `COMPRESSED`=1, a first parcel whose bits [1:0] are not 11 (and that is not all zero) completes a one-parcel instruction with `out_kind`=0 (normal).
- R2: A first parcel with bits [1:0]=11 and bits [4:2] not 111 yields a two-parcel instruction.
- R3: Low six bits 011111 yield three parcels. Low seven bits 0111111 yield four parcels.
- R4: Low seven bits all ones give 5+n parcels, where n = bits [14:12]. If n=111, `out_kind`=2 (reserved) and the block consumes ILEN/16 parcels.
- R5: The first parcel received lands in `out_data[15:0]` and each later parcel goes 16 bits higher. All bits above the reported length are zero.
- R6: An all-zero first parcel is flagged `out_kind`=1 (illegal). Its length is one parcel with `COMPRESSED`=1 and two parcels otherwise.
- R7: An assembled word whose ILEN bits are all ones is flagged illegal, with length ILEN/16.
- R8: With `COMPRESSED`=0, a first parcel whose bits [1:0] are not 11 is flagged illegal and consumes one parcel.
- R9: A decoded length above ILEN is flagged illegal, and the block consumes exactly ILEN/16 parcels so that the stream stays aligned.
- R10: After reset `out_valid`=0 and `in_ready`=1. While `out_valid` is high and `out_ready` is low, `out_data`, `out_len` and `out_kind` hold, and `in_ready` is low.
- R11: While `flush` is high, any partial instruction is discarded and a parcel offered in that cycle is dropped. The next accepted parcel starts a new instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Drop any partial instruction |
| in_valid | input | 1 | Parcel offered |
| in_ready | output | 1 | Parcel can be taken |
| in_parcel | input | 16 | Next parcel in address order |
| out_valid | output | 1 | Assembled instruction present |
| out_ready | input | 1 | Consumer takes the instruction |
| out_data | output | ILEN | Instruction, right-aligned, zero-padded |
| out_len | output | $clog2(ILEN/16+1) | Parcels consumed |
| out_kind | output | 2 | 0 normal, 1 illegal, 2 reserved |

## Verification
The bench targets length codes that lie just beyond the default ILEN of 64 bits. A design that trusted such a length would swallow too many parcels and then misframe every instruction after it. The reserved 3-bit count value is covered both with ordinary trailing parcels and with all-ones trailing parcels; a wrong priority between these cases would report reserved where illegal is due. The all-zero parcel is tested on both variants, where an error shows up as a wrong parcel count. A flush that arrives together with a parcel is tested as well: a block that kept the stale half-instruction would merge it with the next one and produce a wrong word.

// File: rtl/pa_pkg.sv
package pa_pkg;
    localparam int PW = 16;

    typedef enum logic [1:0] {
        KIND_OK       = 2'd0,
        KIND_ILLEGAL  = 2'd1,
        KIND_RESERVED = 2'd2
    } pa_kind_e;
endpackage

// File: rtl/pa_len_decode.sv
module pa_len_decode
    import pa_pkg::*;
#(
    parameter int ILEN       = 64,
    parameter bit COMPRESSED = 1'b1,
    localparam int MAXP      = ILEN / PW,
    localparam int LW        = $clog2(MAXP + 1),
    localparam int RW        = (LW > 4) ? LW : 4
) (
    input  logic [PW-1:0] parcel,
    output logic [LW-1:0] consume,
    output pa_kind_e      kind
);
    logic [RW-1:0] raw;

    always_comb begin
        raw  = '0;
        kind = KIND_OK;
        if (parcel == '0) begin
            raw  = COMPRESSED ? RW'(1) : RW'(2);
            kind = KIND_ILLEGAL;
        end else if (parcel[1:0] != 2'b11) begin
            raw  = RW'(1);
            kind = COMPRESSED ? KIND_OK : KIND_ILLEGAL;
        end else if (parcel[4:2] != 3'b111) begin
            raw = RW'(2);
        end else if (!parcel[5]) begin
            raw = RW'(3);
        end else if (!parcel[6]) begin
            raw = RW'(4);
        end else if (parcel[14:12] != 3'b111) begin
            raw = RW'(5) + RW'(parcel[14:12]);
        end else begin
            raw  = RW'(MAXP);
            kind = KIND_RESERVED;
        end
        if (raw > RW'(MAXP)) begin
            raw  = RW'(MAXP);
            kind = KIND_ILLEGAL;
        end
        consume = LW'(raw);
    end
endmodule

// File: rtl/pa_ones_detect.sv
module pa_ones_detect #(
    parameter int W = 64
) (
    input  logic [W-1:0] word,
    output logic         all_ones
);
    assign all_ones = &word;
endmodule

// File: rtl/parcel_assembler.sv
module parcel_assembler
    import pa_pkg::*;
#(
    parameter int ILEN       = 64,
    parameter bit COMPRESSED = 1'b1,
    localparam int MAXP      = ILEN / PW,
    localparam int LW        = $clog2(MAXP + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [PW-1:0]   in_parcel,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [ILEN-1:0] out_data,
    output logic [LW-1:0]   out_len,
    output logic [1:0]      out_kind
);
    typedef struct packed {
        logic [ILEN-1:0] word;
        logic [LW-1:0]   cnt;
        logic [LW-1:0]   need;
        pa_kind_e        kind;
        logic [LW-1:0]   olen;
        logic            ovalid;
    } st_t;

    st_t q, d;

    logic [LW-1:0]   dec_consume;
    pa_kind_e        dec_kind;
    logic [ILEN-1:0] word_next;
    logic            word_ones;
    logic [LW-1:0]   need_now;
    pa_kind_e        kind_now;
    logic            fire;
    logic            last_beat;

    pa_len_decode #(.ILEN(ILEN), .COMPRESSED(COMPRESSED)) u_dec (
        .parcel  (in_parcel),
        .consume (dec_consume),
        .kind    (dec_kind)
    );

    pa_ones_detect #(.W(ILEN)) u_ones (
        .word     (word_next),
        .all_ones (word_ones)
    );

    always_comb begin
        word_next = (q.cnt == '0) ? '0 : q.word;
        for (int i = 0; i < MAXP; i++) begin
            if (LW'(i) == q.cnt) word_next[i*PW +: PW] = in_parcel;
        end
    end

    assign fire      = in_valid && in_ready;
    assign need_now  = (q.cnt == '0) ? dec_consume : q.need;
    assign kind_now  = (q.cnt == '0) ? dec_kind : q.kind;
    assign last_beat = ((LW+1)'(q.cnt) + (LW+1)'(1)) == (LW+1)'(need_now);

    always_comb begin
        d = q;
        if (q.ovalid && out_ready) d.ovalid = 1'b0;
        if (flush) begin
            d.cnt = '0;
        end else if (fire) begin
            d.word = word_next;
            d.need = need_now;
            d.kind = kind_now;
            if (last_beat) begin
                d.cnt    = '0;
                d.ovalid = 1'b1;
                d.olen   = need_now;
                if (word_ones) d.kind = KIND_ILLEGAL;
            end else begin
                d.cnt = q.cnt + LW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_ready  = !q.ovalid;
    assign out_valid = q.ovalid;
    assign out_data  = q.word;
    assign out_len   = q.olen;
    assign out_kind  = q.kind;

    logic [ILEN-1:0] pad_mask;
    always_comb begin
        for (int i = 0; i < MAXP; i++) begin
            pad_mask[i*PW +: PW] = (LW'(i) < out_len) ? '1 : '0;
        end
    end

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_len) && $stable(out_kind));
    a_r10_rise_from_beat: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && !flush));
    a_r5_zero_pad: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data & ~pad_mask) == '0);
    a_r9_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_len != '0 && out_len <= LW'(MAXP));
    a_r4_reserved_len: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind == 2'd2 |-> out_len == LW'(MAXP));
    a_r7_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (&out_data) |-> out_kind == 2'd1);
    a_r11_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush && !out_valid |=> !out_valid);
endmodule

// File: tb/test_parcel_assembler.sv
module test_parcel_assembler;
    localparam int ILEN = 64;
    localparam int MAXP = ILEN / 16;
    localparam int LW   = $clog2(MAXP + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic            flush = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
    logic [15:0]     in_parcel = '0;
    logic            in_ready, out_valid;
    logic [ILEN-1:0] out_data;
    logic [LW-1:0]   out_len;
    logic [1:0]      out_kind;

    logic            nc_in_valid = 1'b0;
    logic [15:0]     nc_in_parcel = '0;
    logic            nc_in_ready, nc_out_valid;
    logic [ILEN-1:0] nc_out_data;
    logic [LW-1:0]   nc_out_len;
    logic [1:0]      nc_out_kind;

    parcel_assembler #(.ILEN(ILEN), .COMPRESSED(1'b1)) i_parcel_assembler (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
        .in_parcel(in_parcel), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_len(out_len), .out_kind(out_kind));

    parcel_assembler #(.ILEN(ILEN), .COMPRESSED(1'b0)) i_parcel_assembler_nc (
        .clk(clk), .rst_n(rst_n), .flush(1'b0), .in_valid(nc_in_valid), .in_ready(nc_in_ready),
        .in_parcel(nc_in_parcel), .out_valid(nc_out_valid), .out_ready(1'b1),
        .out_data(nc_out_data), .out_len(nc_out_len), .out_kind(nc_out_kind));

    int total = 0, bad = 0;
    bit mon_en = 1'b0;

    logic [15:0]     par_q[$];
    logic [ILEN-1:0] exp_word_q[$];
    int              exp_len_q[$];
    int              exp_kind_q[$];
    string           exp_tag_q[$];

    task automatic chk(input bit ok, input string req, input logic [ILEN-1:0] act, input logic [ILEN-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model(input logic [15:0] p, input bit comp, output int len, output int kind);
        kind = 0;
        if (p == 16'h0000) begin len = comp ? 1 : 2; kind = 1; end
        else if (p[1:0] != 2'b11) begin len = 1; kind = comp ? 0 : 1; end
        else if (p[4:2] != 3'b111) len = 2;
        else if (!p[5]) len = 3;
        else if (!p[6]) len = 4;
        else if (p[14:12] != 3'b111) len = 5 + int'(p[14:12]);
        else begin len = MAXP; kind = 2; end
        if (len > MAXP) begin len = MAXP; kind = 1; end
    endfunction

    task automatic push_instr(input logic [15:0] first, input bit ones, input string tag);
        int len, kind;
        logic [ILEN-1:0] w;
        logic [15:0] p;
        model(first, 1'b1, len, kind);
        w = '0;
        w[15:0] = first;
        par_q.push_back(first);
        for (int i = 1; i < len; i++) begin
            p = ones ? 16'hFFFF : 16'($urandom);
            w[i*16 +: 16] = p;
            par_q.push_back(p);
        end
        if (&w) kind = 1;
        exp_word_q.push_back(w);
        exp_len_q.push_back(len);
        exp_kind_q.push_back(kind);
        exp_tag_q.push_back(tag);
    endtask

    task automatic send_parcel(input logic [15:0] p);
        bit acc;
        @(negedge clk);
        in_valid = 1'b1;
        in_parcel = p;
        forever begin
            acc = in_ready;
            @(posedge clk);
            if (acc) break;
            @(negedge clk);
        end
    endtask

    task automatic drive_all();
        while (par_q.size() > 0) begin
            if ($urandom % 4 == 0) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
            send_parcel(par_q.pop_front());
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 2000 && exp_word_q.size() > 0; i++) @(negedge clk);
        chk(exp_word_q.size() == 0, "R10 drain", ILEN'(exp_word_q.size()), '0);
    endtask

    // Monitor: random back-pressure, stability and ordering checks
    bit stalled = 1'b0;
    logic [ILEN-1:0] sv_data;
    logic [LW-1:0]   sv_len;
    logic [1:0]      sv_kind;
    always @(negedge clk) begin
        if (mon_en) begin
            bit rdy;
            if (stalled && out_valid)
                chk(out_data == sv_data && out_len == sv_len && out_kind == sv_kind,
                    "R10 hold", out_data, sv_data);
            if (out_valid)
                chk(in_ready == 1'b0, "R10 in_ready low", ILEN'(in_ready), '0);
            rdy = ($urandom % 4) != 0;
            out_ready = rdy;
            stalled = out_valid && !rdy;
            sv_data = out_data; sv_len = out_len; sv_kind = out_kind;
            if (out_valid && rdy) begin
                if (exp_word_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected output", out_data, '0);
                end else begin
                    string t;
                    t = exp_tag_q.pop_front();
                    chk(out_data == exp_word_q[0], {"R5 data ", t}, out_data, exp_word_q[0]);
                    chk(int'(out_len) == exp_len_q[0], {t, " length"}, ILEN'(out_len), ILEN'(exp_len_q[0]));
                    chk(int'(out_kind) == exp_kind_q[0], {t, " kind"}, ILEN'(out_kind), ILEN'(exp_kind_q[0]));
                    void'(exp_word_q.pop_front());
                    void'(exp_len_q.pop_front());
                    void'(exp_kind_q.pop_front());
                end
            end
        end
    end

    task automatic nc_send(input logic [15:0] p);
        bit acc;
        @(negedge clk);
        nc_in_valid = 1'b1;
        nc_in_parcel = p;
        forever begin
            acc = nc_in_ready;
            @(posedge clk);
            if (acc) break;
            @(negedge clk);
        end
    endtask

    task automatic nc_case(input logic [15:0] p0, input logic [15:0] p1, input int n,
                           input int elen, input int ekind, input string req);
        logic [ILEN-1:0] ew;
        nc_send(p0);
        if (n > 1) nc_send(p1);
        @(negedge clk);
        nc_in_valid = 1'b0;
        ew = (n > 1) ? ILEN'({p1, p0}) : ILEN'(p0);
        chk(nc_out_valid == 1'b1, {req, " valid"}, ILEN'(nc_out_valid), 1);
        chk(int'(nc_out_len) == elen, {req, " length"}, ILEN'(nc_out_len), ILEN'(elen));
        chk(int'(nc_out_kind) == ekind, {req, " kind"}, ILEN'(nc_out_kind), ILEN'(ekind));
        chk(nc_out_data == ew, {req, " data"}, nc_out_data, ew);
    endtask

    bit done = 1'b0;
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 reset out_valid", ILEN'(out_valid), '0);
        chk(in_ready == 1'b1, "R10 reset in_ready", ILEN'(in_ready), 1);

        // R11: flush drops a half instruction and the parcel offered with it
        send_parcel(16'h0003);
        @(negedge clk);
        flush = 1'b1; in_valid = 1'b1; in_parcel = 16'h0001;
        @(posedge clk);
        @(negedge clk);
        flush = 1'b0; in_valid = 1'b0;
        chk(out_valid == 1'b0, "R11 no output after flush", ILEN'(out_valid), '0);
        mon_en = 1'b1;
        push_instr(16'h1235, 1'b0, "R11 after flush");
        push_instr(16'h0003, 1'b0, "R11 next");
        drive_all();
        drain();

        // Directed length codes
        push_instr(16'h0001, 1'b0, "R1");
        push_instr(16'hFFFE, 1'b0, "R1");
        push_instr(16'h0000, 1'b0, "R6");
        push_instr(16'h0013, 1'b0, "R2");
        push_instr(16'h801B, 1'b0, "R2");
        push_instr(16'h001F, 1'b0, "R3");
        push_instr(16'h003F, 1'b0, "R3");
        push_instr(16'h007F, 1'b0, "R9");
        push_instr(16'h607F, 1'b0, "R9");
        push_instr(16'h707F, 1'b0, "R4");
        push_instr(16'hFFFF, 1'b0, "R4");
        push_instr(16'hFFFF, 1'b1, "R7");
        push_instr(16'h0002, 1'b0, "R1");
        drive_all();
        drain();

        // Random mix biased toward each length class
        for (int k = 0; k < 300; k++) begin
            logic [15:0] f;
            f = 16'($urandom);
            case ($urandom % 6)
                0: f[1:0] = 2'b01;
                1: begin f[1:0] = 2'b11; f[4:2] = 3'b010; end
                2: f[5:0] = 6'b011111;
                3: f[6:0] = 7'b0111111;
                4: f[6:0] = 7'b1111111;
                default: ;
            endcase
            push_instr(f, 1'b0, "random");
        end
        drive_all();
        drain();
        mon_en = 1'b0;

        // Variant without one-parcel instructions
        nc_case(16'h0000, 16'h1234, 2, 2, 1, "R6 nc zero");
        nc_case(16'h0005, 16'h0000, 1, 1, 1, "R8 nc short");
        nc_case(16'h0013, 16'h5678, 2, 2, 0, "R2 nc normal");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule